// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit turns a decoded memory-access request into the address, size and direction presented to a data memory. It serves byte and halfword loads and stores. Each request carries an addressing-mode code, a base value (an address register or the stack pointer, chosen upstream), an index data register value, the low 16 bits of the instruction word, a 32-bit extension word and the source data for stores. One clock later the unit shows a valid strobe with the effective address, the access width, the direction and the store data trimmed to the access width.

On the return path the unit zero-extends the byte or halfword that memory delivers into a full destination-register value. The width used is the one captured with the access. The short-displacement forms treat their offset differently by base. Offsets on an address register are signed. Offsets on the stack pointer are unsigned. Address arithmetic wraps around the 32-bit space, and the unit applies no alignment rule.

Top module: `lsu_agen`

## Requirements
- R1: Mode codes 0 and 1 add the base to an 8-bit (`insn_lo[7:0]`) or 16-bit (`insn_lo`) displacement that is sign-extended to 32 bits first. Code 9 uses the base alone.
- R2: Mode codes 3 and 4 add the base (stack pointer) to an 8-bit or 16-bit displacement that is zero-extended first.
- R3: Mode codes 2 and 5 add the base to (`insn_lo` shifted left by 16) plus `ext_word`. Code 8 uses (`insn_lo` << 16) + `ext_word` with no base.
- R4: Mode code 6 adds the base and `index_val`, with no displacement.
- R5: Mode code 7 uses `insn_lo` zero-extended to 32 bits as the address, and bits 31..16 of the address are zero.
- R6: All sums wrap modulo 2^32. An odd address with a halfword access is passed through unchanged.
- R7: `acc_valid` is high in the cycle after an edge where `req_valid` was high with a mode code of 0..9. Codes 10..15 produce no strobe.
- R8: `acc_half` (1 = halfword, 0 = byte) and `acc_store` (1 = store, 0 = load) are the request's `req_half` and `req_store`, shown with the same one-cycle latency.
- R9: For a store, `acc_wdata` holds the low 8 bits (byte) or low 16 bits (halfword) of `store_src`, with all higher bits zero. For a load it is zero.
- R10: `ld_data` is `mem_rdata[7:0]` zero-extended when `acc_half` is 0, and `mem_rdata[15:0]` zero-extended when it is 1. It is combinational from `mem_rdata`.
- R11: After reset, `acc_valid`, `acc_addr`, `acc_half`, `acc_store` and `acc_wdata` are all zero.
- R12: In a cycle with no accepted request, `acc_addr`, `acc_half`, `acc_store` and `acc_wdata` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing-mode code (0..9 legal) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| base_val | input | 32 | Address register or stack pointer value |
| index_val | input | 32 | Index data register value |
| insn_lo | input | 16 | Low 16 bits of the instruction word |
| ext_word | input | 32 | Extension word |
| store_src | input | 32 | Source data register for stores |
| mem_rdata | input | 16 | Data returned by memory for a load |
| acc_valid | output | 1 | Access strobe |
| acc_addr | output | 32 | Effective address |
| acc_half | output | 1 | Access width of the strobed access |
| acc_store | output | 1 | Direction of the strobed access |
| acc_wdata | output | 32 | Width-trimmed store data |
| ld_data | output | 32 | Zero-extended load result |

## Verification
The hardest cases to reach are those where the sign of a short displacement changes the sum. These are a displacement with its top bit set, applied both to an address-register base and to the stack pointer. Sums that wrap past 2^32 are equally hard. The stimulus sets these up directly by driving displacements of 0x80, 0xFF and 0x8000 on both base kinds, and by driving bases near 0xFFFFFFFF. Random traffic across all sixteen mode codes then mixes them with illegal codes and idle cycles, which exercises the hold behaviour.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

   typedef enum logic [3:0] {
      AM_AR_D8   = 4'd0,
      AM_AR_D16  = 4'd1,
      AM_AR_D32  = 4'd2,
      AM_SP_D8   = 4'd3,
      AM_SP_D16  = 4'd4,
      AM_SP_D32  = 4'd5,
      AM_INDEX   = 4'd6,
      AM_ABS16   = 4'd7,
      AM_ABS32   = 4'd8,
      AM_AR_IND  = 4'd9
   } amode_e;

   localparam int unsigned AMODE_LAST = 9;

   function automatic logic amode_legal(input logic [3:0] m);
      return (m <= 4'(AMODE_LAST));
   endfunction

endpackage

// File: rtl/lsu_agen_offset.sv
module lsu_agen_offset
   import lsu_agen_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned LO_W    = 16,
   parameter int unsigned SHORT_W = 8,
   parameter bit          SP_ZEXT = 1'b1
) (
   input  logic [3:0]        mode,
   input  logic [LO_W-1:0]   insn_lo,
   input  logic [ADDR_W-1:0] ext_word,
   input  logic [ADDR_W-1:0] index_val,
   output logic [ADDR_W-1:0] offset,
   output logic              use_base
);

   localparam int unsigned PAD_S = ADDR_W - SHORT_W;
   localparam int unsigned PAD_L = ADDR_W - LO_W;

   if (ADDR_W != 2 * LO_W) begin : g_bad_split
      $error("lsu_agen_offset: ADDR_W must be twice LO_W");
   end
   if (SHORT_W >= LO_W) begin : g_bad_short
      $error("lsu_agen_offset: SHORT_W must be below LO_W");
   end

   logic [ADDR_W-1:0] ar_short, ar_long, sp_short, sp_long, zx_long, wide_disp;

   assign ar_short  = {{PAD_S{insn_lo[SHORT_W-1]}}, insn_lo[SHORT_W-1:0]};
   assign ar_long   = {{PAD_L{insn_lo[LO_W-1]}}, insn_lo};
   assign zx_long   = {{PAD_L{1'b0}}, insn_lo};
   assign wide_disp = {insn_lo, {PAD_L{1'b0}}} + ext_word;

   if (SP_ZEXT) begin : g_sp_zext
      assign sp_short = {{PAD_S{1'b0}}, insn_lo[SHORT_W-1:0]};
      assign sp_long  = zx_long;
   end else begin : g_sp_sext
      assign sp_short = ar_short;
      assign sp_long  = ar_long;
   end

   always_comb begin
      offset   = '0;
      use_base = 1'b1;
      case (mode)
         AM_AR_D8:  offset = ar_short;
         AM_AR_D16: offset = ar_long;
         AM_AR_D32: offset = wide_disp;
         AM_SP_D8:  offset = sp_short;
         AM_SP_D16: offset = sp_long;
         AM_SP_D32: offset = wide_disp;
         AM_INDEX:  offset = index_val;
         AM_ABS16: begin
            offset   = zx_long;
            use_base = 1'b0;
         end
         AM_ABS32: begin
            offset   = wide_disp;
            use_base = 1'b0;
         end
         AM_AR_IND: offset = '0;
         default: begin
            offset   = '0;
            use_base = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lsu_agen_sum.sv
module lsu_agen_sum #(
   parameter int unsigned ADDR_W      = 32,
   parameter bit          CARRY_SPLIT = 1'b0
) (
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] offset,
   input  logic              use_base,
   output logic [ADDR_W-1:0] ea
);

   localparam int unsigned HALF_W = ADDR_W / 2;

   if (ADDR_W % 2 != 0) begin : g_bad_width
      $error("lsu_agen_sum: ADDR_W must be even");
   end

   logic [ADDR_W-1:0] base_g;
   assign base_g = use_base ? base_val : '0;

   if (CARRY_SPLIT) begin : g_split
      logic [HALF_W:0]   lo_sum;
      logic [HALF_W-1:0] hi_sum;
      assign lo_sum = {1'b0, base_g[HALF_W-1:0]} + {1'b0, offset[HALF_W-1:0]};
      assign hi_sum = base_g[ADDR_W-1:HALF_W] + offset[ADDR_W-1:HALF_W]
                      + {{(HALF_W-1){1'b0}}, lo_sum[HALF_W]};
      assign ea = {hi_sum, lo_sum[HALF_W-1:0]};
   end else begin : g_flat
      assign ea = base_g + offset;
   end

endmodule

// File: rtl/lsu_agen_zext.sv
module lsu_agen_zext #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  logic              half,
   output logic [DATA_W-1:0] dout
);

   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("lsu_agen_zext: DATA_W must be a multiple of 8 and at least 16");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_keep
         assign dout[8*i +: 8] = din[8*i +: 8];
      end else if (i == 1) begin : g_half
         assign dout[8*i +: 8] = half ? din[8*i +: 8] : 8'h00;
      end else begin : g_clear
         assign dout[8*i +: 8] = din[8*i +: 8] & 8'h00;
      end
   end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_agen_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LO_W        = 16,
   parameter int unsigned RDATA_W     = 16,
   parameter bit          SP_ZEXT     = 1'b1,
   parameter bit          CARRY_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_mode,
   input  logic              req_store,
   input  logic              req_half,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] index_val,
   input  logic [LO_W-1:0]   insn_lo,
   input  logic [ADDR_W-1:0] ext_word,
   input  logic [DATA_W-1:0] store_src,
   input  logic [RDATA_W-1:0] mem_rdata,
   output logic              acc_valid,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_half,
   output logic              acc_store,
   output logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] ld_data
);

   localparam int unsigned RPAD = DATA_W - RDATA_W;

   if (RDATA_W != 16 || DATA_W <= RDATA_W) begin : g_bad_rdata
      $error("lsu_agen: RDATA_W must be 16 and below DATA_W");
   end

   logic [ADDR_W-1:0] offset, ea;
   logic              use_base, accept;
   logic [DATA_W-1:0] st_trim;

   lsu_agen_offset #(
      .ADDR_W (ADDR_W), .LO_W (LO_W), .SHORT_W (8), .SP_ZEXT (SP_ZEXT)
   ) u_offset (
      .mode (req_mode), .insn_lo (insn_lo), .ext_word (ext_word),
      .index_val (index_val), .offset (offset), .use_base (use_base)
   );

   lsu_agen_sum #(
      .ADDR_W (ADDR_W), .CARRY_SPLIT (CARRY_SPLIT)
   ) u_sum (
      .base_val (base_val), .offset (offset), .use_base (use_base), .ea (ea)
   );

   lsu_agen_zext #(.DATA_W (DATA_W)) u_st_trim (
      .din (store_src), .half (req_half), .dout (st_trim)
   );

   lsu_agen_zext #(.DATA_W (DATA_W)) u_ld_ext (
      .din ({{RPAD{1'b0}}, mem_rdata}), .half (acc_half), .dout (ld_data)
   );

   assign accept = req_valid && amode_legal(req_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_addr  <= '0;
         acc_half  <= 1'b0;
         acc_store <= 1'b0;
         acc_wdata <= '0;
      end else begin
         acc_valid <= accept;
         if (accept) begin
            acc_addr  <= ea;
            acc_half  <= req_half;
            acc_store <= req_store;
            acc_wdata <= req_store ? st_trim : '0;
         end
      end
   end

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid == $past(req_valid && (req_mode <= 4'd9)));

   p_ar_short_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(req_mode) == AM_AR_D8) |->
      (ADDR_W'(acc_addr - $past(base_val) + ADDR_W'(128)) < ADDR_W'(256)));

   p_sp_short_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(req_mode) == AM_SP_D8) |->
      (ADDR_W'(acc_addr - $past(base_val)) < ADDR_W'(256)));

   p_abs16_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(req_mode) == AM_ABS16) |->
      (acc_addr[ADDR_W-1:LO_W] == '0));

   p_store_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_store && !acc_half) |-> (acc_wdata[DATA_W-1:8] == '0));

   p_load_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_store) |-> (acc_wdata == '0));

   p_ld_zext_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_data[DATA_W-1:RDATA_W] == '0);

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid && (req_mode <= 4'd9)) |->
      ($stable(acc_addr) && $stable(acc_wdata) && $stable(acc_half)));

endmodule

// File: tb/lsu_agen_tb_top.sv
`timescale 1ns/1ps
module lsu_agen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_mode = '0;
   logic        req_store = 1'b0;
   logic        req_half = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] index_val = '0;
   logic [15:0] insn_lo = '0;
   logic [31:0] ext_word = '0;
   logic [31:0] store_src = '0;
   logic [15:0] mem_rdata = '0;
   logic        acc_valid;
   logic [31:0] acc_addr;
   logic        acc_half;
   logic        acc_store;
   logic [31:0] acc_wdata;
   logic [31:0] ld_data;

   always #2.5 clk = ~clk;

   lsu_agen dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_mode (req_mode),
      .req_store (req_store), .req_half (req_half), .base_val (base_val),
      .index_val (index_val), .insn_lo (insn_lo), .ext_word (ext_word),
      .store_src (store_src), .mem_rdata (mem_rdata), .acc_valid (acc_valid),
      .acc_addr (acc_addr), .acc_half (acc_half), .acc_store (acc_store),
      .acc_wdata (acc_wdata), .ld_data (ld_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] mem [256];

   logic        exp_valid = 1'b0;
   logic [31:0] exp_addr  = '0;
   logic        exp_half  = 1'b0;
   logic        exp_store = 1'b0;
   logic [31:0] exp_wdata = '0;
   string       exp_req   = "R11";

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] want);
      n_tests++;
      if (got !== want) begin
         n_fail++;
         $display("FAIL %s %s: got %08h expected %08h", req, what, got, want);
      end
   endtask

   function automatic string req_of(input int m);
      case (m)
         0, 1, 9: return "R1";
         3, 4:    return "R2";
         2, 5, 8: return "R3";
         6:       return "R4";
         7:       return "R5";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [31:0] ref_ea(input int m, input logic [31:0] b,
      input logic [31:0] ix, input logic [15:0] lo, input logic [31:0] ex);
      longint unsigned wide;
      longint signed   s8, s16;
      wide = (longint'(lo) * 65536) + longint'(ex);
      s8   = (lo[7:0] >= 8'h80) ? longint'(lo[7:0]) - 256 : longint'(lo[7:0]);
      s16  = (lo >= 16'h8000) ? longint'(lo) - 65536 : longint'(lo);
      case (m)
         0: return 32'(longint'(b) + s8);
         1: return 32'(longint'(b) + s16);
         3: return 32'(longint'(b) + longint'(lo[7:0]));
         4: return 32'(longint'(b) + longint'(lo));
         2, 5: return 32'(longint'(b) + wide);
         6: return 32'(longint'(b) + longint'(ix));
         7: return 32'(longint'(lo));
         8: return 32'(wide);
         9: return b;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check_outputs();
      logic [31:0] want_ld;
      chk("R7", "acc_valid", 32'(acc_valid), 32'(exp_valid));
      chk(exp_valid ? exp_req : "R12", "acc_addr", acc_addr, exp_addr);
      chk("R8", "acc_half", 32'(acc_half), 32'(exp_half));
      chk("R8", "acc_store", 32'(acc_store), 32'(exp_store));
      chk("R9", "acc_wdata", acc_wdata, exp_wdata);
      if (exp_valid && !exp_store) begin
         mem_rdata = {mem[8'(acc_addr + 1)], mem[acc_addr[7:0]]};
         #1;
         want_ld = exp_half ? {16'h0, mem[8'(acc_addr + 1)], mem[acc_addr[7:0]]}
                            : {24'h0, mem[acc_addr[7:0]]};
         chk("R10", "ld_data", ld_data, want_ld);
      end
      if (exp_valid && exp_store) begin
         mem[exp_addr[7:0]] = exp_wdata[7:0];
         if (exp_half) mem[8'(exp_addr + 1)] = exp_wdata[15:8];
      end
   endtask

   task automatic drive(input logic v, input int m, input logic st, input logic hf,
      input logic [31:0] b, input logic [31:0] ix, input logic [15:0] lo,
      input logic [31:0] ex, input logic [31:0] src);
      @(negedge clk);
      check_outputs();
      req_valid = v; req_mode = 4'(m); req_store = st; req_half = hf;
      base_val = b; index_val = ix; insn_lo = lo; ext_word = ex; store_src = src;
      exp_valid = v && (m <= 9);
      if (exp_valid) begin
         exp_addr  = ref_ea(m, b, ix, lo, ex);
         exp_half  = hf;
         exp_store = st;
         exp_wdata = st ? (hf ? {16'h0, src[15:0]} : {24'h0, src[7:0]}) : 32'h0;
         exp_req   = req_of(m);
      end
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "reset acc_valid", 32'(acc_valid), 32'h0);
      chk("R11", "reset acc_addr", acc_addr, 32'h0);
      chk("R11", "reset acc_wdata", acc_wdata, 32'h0);
      chk("R11", "reset acc_half", 32'(acc_half), 32'h0);
      // R1: signed short displacement on address register
      drive(1, 0, 0, 0, 32'h0000_1000, 0, 16'h0080, 0, 0);
      drive(1, 1, 0, 1, 32'h0000_1000, 0, 16'h8000, 0, 0);
      drive(1, 0, 1, 0, 32'h0000_2000, 0, 16'h007F, 0, 32'hDEAD_BEA5);
      drive(1, 9, 0, 0, 32'h0000_2000, 0, 16'hFFFF, 32'h1234, 0);
      // R2: unsigned short displacement on stack pointer
      drive(1, 3, 0, 0, 32'h0000_1000, 0, 16'h00FF, 0, 0);
      drive(1, 4, 1, 1, 32'h0000_1000, 0, 16'h8000, 0, 32'hCAFE_1234);
      // R3: wide forms
      drive(1, 2, 0, 1, 32'h0000_0010, 0, 16'h0001, 32'h0000_0020, 0);
      drive(1, 5, 1, 0, 32'h0000_0100, 0, 16'hFFFF, 32'h0001_0003, 32'h55);
      drive(1, 8, 0, 0, 32'hFFFF_FFFF, 0, 16'h1234, 32'h0000_5678, 0);
      // R4: indexed
      drive(1, 6, 0, 1, 32'h0000_0040, 32'h0000_0003, 16'h7777, 32'h9999, 0);
      // R5: absolute 16-bit stays zero-extended
      drive(1, 7, 0, 0, 32'hFFFF_FFFF, 0, 16'hF00D, 0, 0);
      // R6: wrap and odd halfword address
      drive(1, 0, 0, 1, 32'h0000_0000, 0, 16'h00FF, 0, 0);
      drive(1, 3, 1, 1, 32'hFFFF_FFFF, 0, 16'h0002, 0, 32'h0000_ABCD);
      drive(1, 6, 0, 1, 32'hFFFF_FFF0, 32'h0000_0031, 0, 0, 0);
      // R7 / R12: illegal codes and idle cycles hold the outputs
      drive(1, 12, 1, 1, 32'h1111_1111, 0, 16'h2222, 0, 32'hFFFF);
      drive(0, 0, 1, 0, 32'h3333_3333, 0, 16'h4444, 0, 32'hFF);
      drive(1, 15, 0, 0, 0, 0, 0, 0, 0);
      // R9: halfword store then byte load of the same bytes, R10
      drive(1, 7, 1, 1, 0, 0, 16'h0030, 0, 32'hFFFF_8001);
      drive(1, 7, 0, 1, 0, 0, 16'h0030, 0, 0);
      drive(1, 7, 0, 0, 0, 0, 16'h0031, 0, 0);
      // random mix across all codes
      for (int k = 0; k < 400; k++) begin
         drive(($urandom % 8) != 0, int'($urandom % 16), 1'($urandom), 1'($urandom),
               (($urandom % 4) == 0) ? 32'hFFFF_FF00 | ($urandom % 256) : $urandom,
               $urandom, 16'($urandom), $urandom, $urandom);
      end
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule